// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of a branch instruction once its opcode and operands are known. The decode stage presents an 8-bit opcode together with a flag that marks a Y-index prefix byte, the four arithmetic flags, a signed 8-bit displacement and the address of the following instruction. For the bit-test branch forms it also presents the fetched memory byte and an 8-bit mask. On a one-cycle `valid_i` strobe the block decides whether the branch is taken. It forms the next program counter and looks up how many bus cycles the instruction costs.

Relative branches test one of sixteen conditions built from the flags. These cover the plain flag tests and the unsigned and two's-complement comparisons. The subroutine-call branch is always taken. The bit-test branches AND the memory byte with the mask. The bit-clear form is taken when every selected bit is 0. The bit-set form is taken when every selected bit is 1. Their cost depends on the addressing mode.

All results, including a copy of the flags, are registered one cycle after the strobe. They stay unchanged until the next strobe. An opcode the block does not recognise raises `illegal_o` and is reported as not taken.

Top module: `branch_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `taken_o`, `illegal_o`, `pc_o`, `cycles_o` and `flags_o` all become 0.
- R2: Outputs update only at the edge where `valid_i` is high; with `valid_i` low all outputs keep their values whatever the other inputs do.
- R3: Opcode 0x20 is always taken and 0x21 is never taken. Opcode 0x8D (subroutine call) is always taken and reports 6 cycles.
- R4: Unsigned conditions, with flags packed as `flags_i[3]`=N, `[2]`=Z, `[1]`=V, `[0]`=C: 0x22 is taken when C|Z=0, 0x23 when C|Z=1, 0x24 when C=0 and 0x25 when C=1.
- R5: Single-flag conditions: 0x26 is taken on Z=0 and 0x27 on Z=1. 0x28 is taken on V=0 and 0x29 on V=1. 0x2A is taken on N=0 and 0x2B on N=1.
- R6: Signed conditions: 0x2C is taken when N^V=0 and 0x2D when N^V=1. 0x2E is taken when Z|(N^V)=0 and 0x2F when Z|(N^V)=1.
- R7: Every opcode 0x20 to 0x2F reports 3 cycles.
- R8: For a recognised opcode, `pc_o` is `next_pc_i` plus the sign-extended displacement, modulo 2^16, when taken, and `next_pc_i` when not taken.
- R9: Bit-clear branches (0x13, 0x1F) are taken when `mem_i & mask_i` is 0.
- R10: Bit-set branches (0x12, 0x1E) are taken when `~mem_i & mask_i` is 0; a zero mask makes both bit-test forms taken.
- R11: Bit-test cycle counts are 6 for 0x12/0x13, 7 for 0x1E/0x1F without prefix, and 8 for 0x1E/0x1F with `prefix_y_i`=1.
- R12: Any other opcode, or `prefix_y_i`=1 with an opcode other than 0x1E/0x1F, gives `illegal_o`=1, `taken_o`=0, `pc_o`=`next_pc_i` and `cycles_o`=0.
- R13: `flags_o` equals `flags_i` as captured at the strobe; no branch alters a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Strobe: resolve the presented instruction |
| prefix_y_i | input | 1 | Y-index prefix byte preceded the opcode |
| opcode_i | input | 8 | Branch opcode |
| flags_i | input | 4 | N, Z, V, C (bit 3 down to bit 0) |
| disp_i | input | 8 | Signed relative displacement |
| mem_i | input | 8 | Memory byte for bit-test branches |
| mask_i | input | 8 | Bit-test mask |
| next_pc_i | input | 16 | Address of the following instruction |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Opcode not recognised |
| pc_o | output | 16 | Next program counter |
| cycles_o | output | 4 | Instruction cycle count |
| flags_o | output | 4 | Flags carried through unchanged |

## Verification
The assertions assume that every input is at a known value at the edge where `valid_i` is high. They also assume the displacement is narrower than the program counter, so sign extension is defined. They do not assume that the inputs stay put between strobes. The stimulus therefore scrambles all data inputs on idle cycles to confirm that the outputs hold. Opcodes are drawn mostly from the recognised set, with and without the prefix, plus arbitrary bytes. Directed cases cover address wraparound, the displacement extremes 0x7F and 0x80, and a zero mask.

// File: rtl/brr_pkg.sv
package brr_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_REL,
        CLS_CALL,
        CLS_BCLR,
        CLS_BSET
    } brr_class_e;

    typedef enum logic [1:0] {
        AM_REL,
        AM_DIR,
        AM_IDX_X,
        AM_IDX_Y
    } brr_mode_e;

    typedef struct packed {
        brr_class_e cls;
        brr_mode_e  mode;
    } brr_decode_t;

    localparam logic [7:0] OP_CALL     = 8'h8D;
    localparam logic [7:0] OP_BSET_DIR = 8'h12;
    localparam logic [7:0] OP_BCLR_DIR = 8'h13;
    localparam logic [7:0] OP_BSET_IDX = 8'h1E;
    localparam logic [7:0] OP_BCLR_IDX = 8'h1F;

    function automatic brr_decode_t brr_decode(input logic [7:0] op, input logic pfx);
        brr_decode_t d;
        d.cls  = CLS_NONE;
        d.mode = AM_REL;
        if (pfx) begin
            if (op == OP_BSET_IDX) begin
                d.cls  = CLS_BSET;
                d.mode = AM_IDX_Y;
            end else if (op == OP_BCLR_IDX) begin
                d.cls  = CLS_BCLR;
                d.mode = AM_IDX_Y;
            end
        end else if (op[7:4] == 4'h2) begin
            d.cls = CLS_REL;
        end else begin
            case (op)
                OP_CALL:     d.cls = CLS_CALL;
                OP_BSET_DIR: begin d.cls = CLS_BSET; d.mode = AM_DIR;   end
                OP_BCLR_DIR: begin d.cls = CLS_BCLR; d.mode = AM_DIR;   end
                OP_BSET_IDX: begin d.cls = CLS_BSET; d.mode = AM_IDX_X; end
                OP_BCLR_IDX: begin d.cls = CLS_BCLR; d.mode = AM_IDX_X; end
                default:     d.cls = CLS_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/brr_cond_eval.sv
module brr_cond_eval (
    input  logic [2:0] sel_i,
    input  logic       odd_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);
    logic n_f, z_f, v_f, c_f, lt_f, base;

    always_comb begin
        n_f  = flags_i[3];
        z_f  = flags_i[2];
        v_f  = flags_i[1];
        c_f  = flags_i[0];
        lt_f = n_f ^ v_f;
        case (sel_i)
            3'd0:    base = 1'b0;
            3'd1:    base = c_f | z_f;
            3'd2:    base = c_f;
            3'd3:    base = z_f;
            3'd4:    base = v_f;
            3'd5:    base = n_f;
            3'd6:    base = lt_f;
            default: base = z_f | lt_f;
        endcase
        // odd opcodes test the condition itself, even ones its complement
        pass_o = odd_i ? base : ~base;
    end
endmodule

// File: rtl/brr_mask_eval.sv
module brr_mask_eval #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              want_set_i,
    output logic              hit_o
);
    logic [DATA_W-1:0] miss;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign miss[gi] = mask_i[gi] & (data_i[gi] ^ want_set_i);
    end

    assign hit_o = ~|miss;
endmodule

// File: rtl/brr_target.sv
module brr_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]   target_o
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    assign target_o = base_i + disp_ext;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brr_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int DISP_W    = 8,
    parameter int DATA_W    = 8,
    parameter int CYC_W     = 4,
    parameter int CYC_REL   = 3,
    parameter int CYC_CALL  = 6,
    parameter int CYC_DIR   = 6,
    parameter int CYC_IDX_X = 7,
    parameter int CYC_IDX_Y = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              prefix_y_i,
    input  logic [7:0]        opcode_i,
    input  logic [3:0]        flags_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [PC_W-1:0]   next_pc_i,
    output logic              taken_o,
    output logic              illegal_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [CYC_W-1:0]  cycles_o,
    output logic [3:0]        flags_o
);
    typedef struct packed {
        logic             taken;
        logic             illegal;
        logic [CYC_W-1:0] cycles;
        logic [3:0]       flags;
        logic [PC_W-1:0]  pc;
    } res_t;

    res_t        res_d, res_q;
    brr_decode_t dec;
    logic        cond_pass;
    logic        mask_hit;
    logic        is_set_form;
    logic [PC_W-1:0] target;

    assign dec         = brr_decode(opcode_i, prefix_y_i);
    assign is_set_form = (dec.cls == CLS_BSET);

    brr_cond_eval u_cond (
        .sel_i   (opcode_i[3:1]),
        .odd_i   (opcode_i[0]),
        .flags_i (flags_i),
        .pass_o  (cond_pass)
    );

    brr_mask_eval #(.DATA_W(DATA_W)) u_mask (
        .data_i     (mem_i),
        .mask_i     (mask_i),
        .want_set_i (is_set_form),
        .hit_o      (mask_hit)
    );

    brr_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
        .base_i   (next_pc_i),
        .disp_i   (disp_i),
        .target_o (target)
    );

    always_comb begin
        res_d = res_q;
        if (valid_i) begin
            res_d.flags   = flags_i;
            res_d.illegal = 1'b0;
            res_d.taken   = 1'b0;
            res_d.cycles  = '0;
            case (dec.cls)
                CLS_REL: begin
                    res_d.taken  = cond_pass;
                    res_d.cycles = CYC_W'(CYC_REL);
                end
                CLS_CALL: begin
                    res_d.taken  = 1'b1;
                    res_d.cycles = CYC_W'(CYC_CALL);
                end
                CLS_BCLR, CLS_BSET: begin
                    res_d.taken = mask_hit;
                    case (dec.mode)
                        AM_IDX_X: res_d.cycles = CYC_W'(CYC_IDX_X);
                        AM_IDX_Y: res_d.cycles = CYC_W'(CYC_IDX_Y);
                        default:  res_d.cycles = CYC_W'(CYC_DIR);
                    endcase
                end
                default: res_d.illegal = 1'b1;
            endcase
            res_d.pc = res_d.taken ? target : next_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign taken_o   = res_q.taken;
    assign illegal_o = res_q.illegal;
    assign pc_o      = res_q.pc;
    assign cycles_o  = res_q.cycles;
    assign flags_o   = res_q.flags;
endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int DATA_W = 8,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic              prefix_y_i,
    input logic [7:0]        opcode_i,
    input logic [3:0]        flags_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [DATA_W-1:0] mem_i,
    input logic [DATA_W-1:0] mask_i,
    input logic [PC_W-1:0]   next_pc_i,
    input logic              taken_o,
    input logic              illegal_o,
    input logic [PC_W-1:0]   pc_o,
    input logic [CYC_W-1:0]  cycles_o,
    input logic [3:0]        flags_o
);
    logic [PC_W-1:0] want_target;
    logic            bclr_dir_clear;

    assign want_target    = next_pc_i + {{(PC_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    assign bclr_dir_clear = valid_i && !prefix_y_i && opcode_i == 8'h13 && (mem_i & mask_i) == '0;

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(taken_o) && $stable(illegal_o) && $stable(pc_o)
                     && $stable(cycles_o) && $stable(flags_o));

    p_bra_taken_r3: assert property (@(posedge clk) disable iff (rst)
        valid_i && !prefix_y_i && opcode_i == 8'h20 |=> taken_o);

    p_brn_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
        valid_i && !prefix_y_i && opcode_i == 8'h21 |=> !taken_o);

    p_taken_target_r8: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> !taken_o || pc_o == $past(want_target));

    p_fallthrough_r8: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> taken_o || pc_o == $past(next_pc_i));

    p_bclr_hit_r9: assert property (@(posedge clk) disable iff (rst)
        bclr_dir_clear |=> taken_o);

    p_illegal_r12: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !taken_o && cycles_o == '0);

    p_legal_cost_r12: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> illegal_o || cycles_o != '0);

    p_flags_r13: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> flags_o == $past(flags_i));
endmodule

bind branch_resolver brr_checker #(
    .PC_W(PC_W), .DISP_W(DISP_W), .DATA_W(DATA_W), .CYC_W(CYC_W)
) chk_i (.*);

// File: tb/branch_resolver_tb_top.sv
module branch_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic        prefix_y_i;
    logic [7:0]  opcode_i;
    logic [3:0]  flags_i;
    logic [7:0]  disp_i;
    logic [7:0]  mem_i;
    logic [7:0]  mask_i;
    logic [15:0] next_pc_i;
    logic        taken_o;
    logic        illegal_o;
    logic [15:0] pc_o;
    logic [3:0]  cycles_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    branch_resolver dut_i (.*);

    // reference model of the requirements
    function automatic bit ref_legal(input logic [7:0] op, input logic pfx);
        if (pfx) return (op == 8'h1E || op == 8'h1F);
        return (op[7:4] == 4'h2) || op == 8'h8D || op == 8'h12 || op == 8'h13
            || op == 8'h1E || op == 8'h1F;
    endfunction

    function automatic bit ref_taken(input logic [7:0] op, input logic pfx,
                                     input logic [3:0] f, input logic [7:0] m,
                                     input logic [7:0] k);
        logic n, z, v, c;
        {n, z, v, c} = f;
        if (!ref_legal(op, pfx)) return 1'b0;
        case (op)
            8'h20: return 1'b1;
            8'h21: return 1'b0;
            8'h22: return !(c || z);
            8'h23: return c || z;
            8'h24: return !c;
            8'h25: return c;
            8'h26: return !z;
            8'h27: return z;
            8'h28: return !v;
            8'h29: return v;
            8'h2A: return !n;
            8'h2B: return n;
            8'h2C: return n == v;
            8'h2D: return n != v;
            8'h2E: return !z && n == v;
            8'h2F: return z || n != v;
            8'h8D: return 1'b1;
            8'h13, 8'h1F: return (m & k) == 8'h00;
            default: return (k & ~m) == 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] ref_cycles(input logic [7:0] op, input logic pfx);
        if (!ref_legal(op, pfx)) return 4'd0;
        if (op[7:4] == 4'h2) return 4'd3;
        if (op == 8'h8D) return 4'd6;
        if (op == 8'h12 || op == 8'h13) return 4'd6;
        return pfx ? 4'd8 : 4'd7;
    endfunction

    function automatic string tag_of(input logic [7:0] op, input logic pfx);
        if (!ref_legal(op, pfx)) return "R12";
        if (op == 8'h20 || op == 8'h21 || op == 8'h8D) return "R3";
        if (op >= 8'h22 && op <= 8'h25) return "R4";
        if (op >= 8'h26 && op <= 8'h2B) return "R5";
        if (op >= 8'h2C && op <= 8'h2F) return "R6";
        if (op == 8'h13 || op == 8'h1F) return "R9";
        return "R10";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic resolve(input logic [7:0] op, input logic pfx, input logic [3:0] f,
                           input logic [7:0] d, input logic [7:0] m, input logic [7:0] k,
                           input logic [15:0] npc);
        bit          tk;
        logic [15:0] tgt;
        logic [3:0]  cy;
        string       tg;
        @(negedge clk);
        valid_i = 1'b1; opcode_i = op; prefix_y_i = pfx; flags_i = f;
        disp_i = d; mem_i = m; mask_i = k; next_pc_i = npc;
        @(negedge clk);
        valid_i = 1'b0;
        tk  = ref_taken(op, pfx, f, m, k);
        tgt = npc + {{8{d[7]}}, d};
        cy  = ref_cycles(op, pfx);
        tg  = tag_of(op, pfx);
        check(tg, "taken", 32'(taken_o), 32'(tk));
        check(ref_legal(op, pfx) ? "R8" : "R12", "pc", 32'(pc_o), 32'(tk ? tgt : npc));
        if (op[7:4] == 4'h2 && !pfx) check("R7", "cycles", 32'(cycles_o), 32'(cy));
        else if (tg == "R9" || tg == "R10") check("R11", "cycles", 32'(cycles_o), 32'(cy));
        else check(tg, "cycles", 32'(cycles_o), 32'(cy));
        check("R12", "illegal", 32'(illegal_o), 32'(!ref_legal(op, pfx)));
        check("R13", "flags", 32'(flags_o), 32'(f));
        // R2: scramble inputs while idle, outputs must hold
        opcode_i = 8'($urandom); prefix_y_i = 1'($urandom); flags_i = 4'($urandom);
        disp_i = 8'($urandom); mem_i = 8'($urandom); mask_i = 8'($urandom);
        next_pc_i = 16'($urandom);
        @(negedge clk);
        check("R2", "hold taken", 32'(taken_o), 32'(tk));
        check("R2", "hold pc", 32'(pc_o), 32'(tk ? tgt : npc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] op;
        logic       pfx;
        logic [7:0] pick [5];
        void'($urandom(32'h5EED_0B1C));
        pick[0] = 8'h12; pick[1] = 8'h13; pick[2] = 8'h1E; pick[3] = 8'h1F; pick[4] = 8'h8D;
        rst = 1'b1; valid_i = 1'b1; prefix_y_i = 1'b0; opcode_i = 8'h20; flags_i = 4'hF;
        disp_i = 8'h10; mem_i = 8'h00; mask_i = 8'h00; next_pc_i = 16'h1234;
        repeat (3) @(negedge clk);
        // R1: reset clears everything even while strobing
        check("R1", "taken", 32'(taken_o), 0);
        check("R1", "illegal", 32'(illegal_o), 0);
        check("R1", "pc", 32'(pc_o), 0);
        check("R1", "cycles", 32'(cycles_o), 0);
        check("R1", "flags", 32'(flags_o), 0);
        valid_i = 1'b0;
        rst = 1'b0;

        // directed corners
        resolve(8'h20, 1'b0, 4'h0, 8'h7F, 8'h00, 8'h00, 16'hFFF0);   // R8 wrap forward
        resolve(8'h20, 1'b0, 4'h0, 8'h80, 8'h00, 8'h00, 16'h0010);   // R8 wrap backward
        resolve(8'h21, 1'b0, 4'hF, 8'h05, 8'h00, 8'h00, 16'h4000);   // R3 never
        resolve(8'h8D, 1'b0, 4'h0, 8'hFE, 8'h00, 8'h00, 16'h8000);   // R3 call
        resolve(8'h13, 1'b0, 4'h0, 8'h04, 8'hAA, 8'h00, 16'h2000);   // R10/R9 zero mask
        resolve(8'h12, 1'b0, 4'h0, 8'h04, 8'h00, 8'h00, 16'h2000);   // R10 zero mask
        resolve(8'h1E, 1'b1, 4'h0, 8'h04, 8'hF0, 8'hF0, 16'h2000);   // R11 Y mode
        resolve(8'h13, 1'b1, 4'h0, 8'h04, 8'h00, 8'hFF, 16'h2000);   // R12 bad prefix
        resolve(8'h2E, 1'b0, 4'b1010, 8'h08, 8'h00, 8'h00, 16'h3000); // R6 N=V
        resolve(8'hFF, 1'b0, 4'h0, 8'h08, 8'h00, 8'h00, 16'h3000);   // R12 unknown

        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 4)
                0: begin op = 8'h20 + 8'($urandom % 16); pfx = ($urandom % 10) == 0; end
                1: begin op = pick[$urandom % 5]; pfx = ($urandom % 10) == 0; end
                2: begin op = 8'($urandom); pfx = ($urandom % 10) == 0; end
                default: begin op = ($urandom % 2) ? 8'h1E : 8'h1F; pfx = 1'b1; end
            endcase
            resolve(op, pfx, 4'($urandom), 8'($urandom), 8'($urandom),
                    ($urandom % 4 == 0) ? 8'($urandom % 4) : 8'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule